// File: doc/BRIEF.md
# Raster Timing Generator with Line Fast-Forward

This block supplies the vertical timing of a character-based video controller. A cycle counter steps through the clock cycles of one raster line. A line counter steps through the lines of one frame. From the current line the block decodes which vertical region the beam is in: top border, display window, bottom border or vertical blank. It also flags whether the line may carry a bad-line fetch.

A static two-bit select chooses one of three frame geometries:
- 312 lines of 63 cycles, a 50 Hz frame.
- 263 lines of 65 cycles.
- 262 lines of 64 cycles.

A fast-forward input forces the line counter to advance on every clock while it is held, without touching the cycle counter. Software can use it to drop raster lines from a frame. Holding it for 25 clocks moves the raster 25 lines ahead.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `cycle_o` and `line_o` become 0, and the region flags take the values decoded for line 0 in the selected geometry.
- R2: `std_sel` encoding: 0 selects 312 lines × 63 cycles, 1 selects 263 × 65, 2 selects 262 × 64, and 3 behaves as 0. `cycle_o` counts 0 up to cycles-per-line minus 1 and then returns to 0.
- R3: With `test_adv` low, `line_o` increments by one exactly on the clock where `cycle_o` returns to 0, and it otherwise holds. After the last line (311, 262 or 261) it goes to 0.
- R4: With `test_adv` high, `line_o` increments by one on every clock and wraps as in R3. `cycle_o` keeps counting normally. A cycle wrap during `test_adv` still gives a single increment.
- R5: In the 312-line geometry: lines 16–50 are top border, 51–250 are display, 251–299 are bottom border, and 300–311 and 0–15 are vertical blank.
- R6: In both the 263-line and the 262-line geometries: lines 41–50 are top border, 51–250 are display, lines 13–40 are vertical blank, and every other line is bottom border. The bottom border therefore wraps through line 0 to line 12.
- R7: `badline_ok_o` is high exactly on lines 48 through 247, in every geometry.
- R8: The flags are registered and change on the same clock as `line_o`. Exactly one of the four region flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 2 | Frame geometry select (static) |
| test_adv | input | 1 | Force one line advance per clock |
| cycle_o | output | 7 | Cycle within line |
| line_o | output | 9 | Raster line |
| top_border_o | output | 1 | Top border region |
| display_o | output | 1 | Display window region |
| bottom_border_o | output | 1 | Bottom border region |
| vblank_o | output | 1 | Vertical blank region |
| badline_ok_o | output | 1 | Line may hold a bad-line fetch |

## Verification
The fast-forward input is used to land the line counter on every region boundary in each geometry. The flags are then compared there. This separates an off-by-one in any boundary from a wrong geometry choice, and it shows the 263-line and 262-line decode agree. Plain free-running stretches of 63, 64 and 65 clocks separate the three line lengths. A fast-forward pulse placed on the last cycle of a line distinguishes a single merged increment from a double step. Reading `cycle_o` after fast-forward shows that the cycle counter runs undisturbed.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int LINE_W = 9;
  localparam int CYC_W  = 7;

  typedef enum logic [1:0] {
    STD_PAL312  = 2'd0,
    STD_NTSC263 = 2'd1,
    STD_NTSC262 = 2'd2,
    STD_RSVD    = 2'd3
  } std_e;

  // frame geometry
  localparam int PAL_LINES  = 312;
  localparam int PAL_CYC    = 63;
  localparam int N263_LINES = 263;
  localparam int N263_CYC   = 65;
  localparam int N262_LINES = 262;
  localparam int N262_CYC   = 64;

  // shared region edges
  localparam int DISP_FIRST = 51;
  localparam int DISP_LAST  = 250;
  localparam int BAD_FIRST  = 48;
  localparam int BAD_LAST   = 247;
  localparam int TOP_LAST   = 50;
  // 50 Hz edges
  localparam int PAL_TOP_FIRST = 16;
  localparam int PAL_BOT_LAST  = 299;
  // 60 Hz edges
  localparam int NT_TOP_FIRST = 41;
  localparam int NT_VB_FIRST  = 13;
  localparam int NT_VB_LAST   = 40;

  typedef struct packed {
    logic top;
    logic disp;
    logic bot;
    logic vb;
    logic bad;
  } region_t;

  function automatic logic [LINE_W-1:0] last_line(std_e s);
    case (s)
      STD_NTSC263: return LINE_W'(N263_LINES - 1);
      STD_NTSC262: return LINE_W'(N262_LINES - 1);
      default:     return LINE_W'(PAL_LINES - 1);
    endcase
  endfunction

  function automatic logic [CYC_W-1:0] last_cycle(std_e s);
    case (s)
      STD_NTSC263: return CYC_W'(N263_CYC - 1);
      STD_NTSC262: return CYC_W'(N262_CYC - 1);
      default:     return CYC_W'(PAL_CYC - 1);
    endcase
  endfunction
endpackage

// File: rtl/raster_cycle_ctr.sv
module raster_cycle_ctr #(
  parameter int CYC_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CYC_W-1:0] last_cyc,
  output logic [CYC_W-1:0] cyc,
  output logic             wrap
);
  assign wrap = (cyc >= last_cyc);

  always_ff @(posedge clk) begin
    if (rst)       cyc <= '0;
    else if (wrap) cyc <= '0;
    else           cyc <= cyc + 1'b1;
  end
endmodule

// File: rtl/raster_line_ctr.sv
module raster_line_ctr #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [LINE_W-1:0] last_ln,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_nxt
);
  always_comb begin
    if (rst)                   line_nxt = '0;
    else if (!step)            line_nxt = line_q;
    else if (line_q >= last_ln) line_nxt = '0;
    else                       line_nxt = line_q + 1'b1;
  end

  always_ff @(posedge clk) line_q <= line_nxt;
endmodule

// File: rtl/raster_region_dec.sv
module raster_region_dec
  import raster_pkg::*;
(
  input  logic [LINE_W-1:0] ln,
  input  std_e              std,
  output region_t           reg_o
);
  logic ntsc;
  assign ntsc = (std == STD_NTSC263) || (std == STD_NTSC262);

  always_comb begin
    reg_o     = '0;
    reg_o.bad = (ln >= LINE_W'(BAD_FIRST)) && (ln <= LINE_W'(BAD_LAST));
    if ((ln >= LINE_W'(DISP_FIRST)) && (ln <= LINE_W'(DISP_LAST)))
      reg_o.disp = 1'b1;
    else if (ntsc) begin
      if ((ln >= LINE_W'(NT_TOP_FIRST)) && (ln <= LINE_W'(TOP_LAST)))
        reg_o.top = 1'b1;
      else if ((ln >= LINE_W'(NT_VB_FIRST)) && (ln <= LINE_W'(NT_VB_LAST)))
        reg_o.vb = 1'b1;
      else
        reg_o.bot = 1'b1;
    end else begin
      if ((ln >= LINE_W'(PAL_TOP_FIRST)) && (ln <= LINE_W'(TOP_LAST)))
        reg_o.top = 1'b1;
      else if ((ln > LINE_W'(DISP_LAST)) && (ln <= LINE_W'(PAL_BOT_LAST)))
        reg_o.bot = 1'b1;
      else
        reg_o.vb = 1'b1;
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        std_sel,
  input  logic              test_adv,
  output logic [CYC_W-1:0]  cycle_o,
  output logic [LINE_W-1:0] line_o,
  output logic              top_border_o,
  output logic              display_o,
  output logic              bottom_border_o,
  output logic              vblank_o,
  output logic              badline_ok_o
);
  std_e              std;
  logic              cyc_wrap;
  logic [LINE_W-1:0] line_nxt;
  region_t           reg_nxt;
  region_t           reg_q;

  assign std = std_e'(std_sel);

  raster_cycle_ctr #(.CYC_W(CYC_W)) u_cyc (
    .clk      (clk),
    .rst      (rst),
    .last_cyc (last_cycle(std)),
    .cyc      (cycle_o),
    .wrap     (cyc_wrap)
  );

  raster_line_ctr #(.LINE_W(LINE_W)) u_line (
    .clk      (clk),
    .rst      (rst),
    .step     (cyc_wrap | test_adv),
    .last_ln  (last_line(std)),
    .line_q   (line_o),
    .line_nxt (line_nxt)
  );

  raster_region_dec u_dec (
    .ln    (line_nxt),
    .std   (std),
    .reg_o (reg_nxt)
  );

  always_ff @(posedge clk) reg_q <= reg_nxt;

  assign top_border_o    = reg_q.top;
  assign display_o       = reg_q.disp;
  assign bottom_border_o = reg_q.bot;
  assign vblank_o        = reg_q.vb;
  assign badline_ok_o    = reg_q.bad;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [1:0]        std_sel,
  input logic              test_adv,
  input logic [CYC_W-1:0]  cycle_o,
  input logic [LINE_W-1:0] line_o,
  input logic              top_border_o,
  input logic              display_o,
  input logic              bottom_border_o,
  input logic              vblank_o,
  input logic              badline_ok_o
);
  logic [CYC_W-1:0]  lc;
  logic [LINE_W-1:0] ll;
  assign lc = last_cycle(std_e'(std_sel));
  assign ll = last_line(std_e'(std_sel));

  p_cycle_range_r2: assert property (@(posedge clk) disable iff (rst)
    cycle_o <= lc);

  p_cycle_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cycle_o < lc) |=> (cycle_o == $past(cycle_o) + 1'b1));

  p_cycle_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cycle_o == lc) |=> (cycle_o == '0));

  p_line_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!test_adv && cycle_o != lc) |=> $stable(line_o));

  p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (cycle_o == lc && line_o == ll) |=> (line_o == '0));

  p_test_step_r4: assert property (@(posedge clk) disable iff (rst)
    (test_adv && line_o < ll) |=> (line_o == $past(line_o) + 1'b1));

  p_region_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot({top_border_o, display_o, bottom_border_o, vblank_o}));

  p_badline_r7: assert property (@(posedge clk) disable iff (rst)
    badline_ok_o == (line_o >= LINE_W'(BAD_FIRST) && line_o <= LINE_W'(BAD_LAST)));

  p_display_r5: assert property (@(posedge clk) disable iff (rst)
    display_o |-> (line_o >= LINE_W'(DISP_FIRST) && line_o <= LINE_W'(DISP_LAST)));
endmodule

bind raster_timing_gen raster_timing_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .std_sel         (std_sel),
  .test_adv        (test_adv),
  .cycle_o         (cycle_o),
  .line_o          (line_o),
  .top_border_o    (top_border_o),
  .display_o       (display_o),
  .bottom_border_o (bottom_border_o),
  .vblank_o        (vblank_o),
  .badline_ok_o    (badline_ok_o)
);

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/100ps
module raster_timing_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] std_sel = 2'd0;
  logic       test_adv = 1'b0;
  logic [6:0] cycle_o;
  logic [8:0] line_o;
  logic       top_border_o, display_o, bottom_border_o, vblank_o, badline_ok_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen u_dut (
    .clk(clk), .rst(rst), .std_sel(std_sel), .test_adv(test_adv),
    .cycle_o(cycle_o), .line_o(line_o), .top_border_o(top_border_o),
    .display_o(display_o), .bottom_border_o(bottom_border_o),
    .vblank_o(vblank_o), .badline_ok_o(badline_ok_o)
  );

  // entry: {std[1:0], line[8:0], top, disp, bot, vb, bad}
  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 9'd0,   5'b00010}, {2'd0, 9'd15,  5'b00010},
    {2'd0, 9'd16,  5'b10000}, {2'd0, 9'd47,  5'b10000},
    {2'd0, 9'd48,  5'b10001}, {2'd0, 9'd50,  5'b10001},
    {2'd0, 9'd51,  5'b01001}, {2'd0, 9'd247, 5'b01001},
    {2'd0, 9'd248, 5'b01000}, {2'd0, 9'd250, 5'b01000},
    {2'd0, 9'd251, 5'b00100}, {2'd0, 9'd299, 5'b00100},
    {2'd0, 9'd300, 5'b00010}, {2'd0, 9'd311, 5'b00010},
    {2'd1, 9'd0,   5'b00100}, {2'd1, 9'd12,  5'b00100},
    {2'd1, 9'd13,  5'b00010}, {2'd1, 9'd40,  5'b00010},
    {2'd1, 9'd41,  5'b10000}, {2'd1, 9'd48,  5'b10001},
    {2'd1, 9'd250, 5'b01000}, {2'd1, 9'd262, 5'b00100},
    {2'd2, 9'd13,  5'b00010}, {2'd2, 9'd261, 5'b00100},
    {2'd3, 9'd20,  5'b10000}, {2'd3, 9'd305, 5'b00010}
  };

  function automatic logic [4:0] flags();
    return {top_border_o, display_o, bottom_border_o, vblank_o, badline_ok_o};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    std_sel = s; rst = 1'b1; test_adv = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // hold test_adv for n clocks; returns at a negedge with test_adv low
  task automatic fast_fwd(input int n);
    if (n > 0) begin
      test_adv = 1'b1;
      repeat (n) @(negedge clk);
      test_adv = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state, 312-line geometry
    do_reset(2'd0);
    check("R1 cycle", cycle_o, 0);
    check("R1 line", line_o, 0);
    check("R1 flags", flags(), 5'b00010);
    // R1 reset state, 263-line geometry: line 0 is bottom border
    do_reset(2'd1);
    check("R1 flags ntsc", flags(), 5'b00100);

    // R5 R6 R7 R8: table walk via fast-forward
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i][15:14]);
      fast_fwd(int'(VEC[i][13:5]));
      check("R4 line", line_o, int'(VEC[i][13:5]));
      check(VEC[i][15:14] == 2'd1 || VEC[i][15:14] == 2'd2 ? "R6 flags" : "R5 flags",
            flags(), VEC[i][4:0]);
    end

    // R2 R3: line lengths per geometry
    for (int s = 0; s < 3; s++) begin
      int len;
      len = (s == 0) ? 63 : (s == 1) ? 65 : 64;
      do_reset(2'(s));
      repeat (len - 1) @(negedge clk);
      check("R2 last cycle", cycle_o, len - 1);
      check("R3 line holds", line_o, 0);
      @(negedge clk);
      check("R2 cycle wraps", cycle_o, 0);
      check("R3 line steps", line_o, 1);
    end

    // R4: cycle counter untouched by fast-forward
    do_reset(2'd0);
    fast_fwd(10);
    check("R4 cycle runs", cycle_o, 10);

    // R4: fast-forward on the last cycle gives a single step
    do_reset(2'd0);
    repeat (62) @(negedge clk);
    fast_fwd(1);
    check("R4 merged step", line_o, 1);
    check("R4 merged cycle", cycle_o, 0);

    // R3 R4: frame wrap in 263-line geometry
    do_reset(2'd1);
    fast_fwd(263);
    check("R4 frame wrap", line_o, 0);
    check("R6 wrap flags", flags(), 5'b00100);

    // R3: natural frame wrap, 262-line geometry
    do_reset(2'd2);
    fast_fwd(261);
    check("R3 at last line", line_o, 261);
    while (cycle_o != 7'd0) @(negedge clk);
    check("R3 natural wrap", line_o, 0);

    finish_run();
  end
endmodule